// File: doc/BRIEF.md
# Forward Control Word Majority Voter

This block sits behind the bit recovery and word decoding of a forward control channel receiver. The channel sends each control word five times in a row, with a busy/idle bit stream interleaved among the words. The block keeps the copies of the current word and forms a bit-by-bit majority over all five. It hands the voted word on to the host with a one-cycle strobe, unless a filter decides the host does not need it.

Two power-saving features are built in. First, an early-vote pin goes LOW as soon as the first three copies agree, so the receiver can be shut down for the last two repeats. It returns HIGH after a programmable delay once the group ends, or at once on a frame restart. Second, a forwarding filter drops words flagged with a BCH error and drops repeated filler words whose identifying fields match the previous filler word. The block also drives a channel busy output, which is the majority of the last three busy/idle bits.

Top module: `fcv_voter`

## Requirements
- R1: Each word_valid_i strobe is one repeat, indexed 0 to 4. On repeat 4 the block forms the bit-by-bit 3-of-5 majority over the five copies of {bch_err_i, filler_i, word_i}. If the voted word is kept, fwd_o pulses for one cycle in the cycle after repeat 4 is sampled, with the voted word on fwd_word_o.
- R2: With early_en_i HIGH, when the word of repeat 2 equals the stored words of repeats 0 and 1, vote_o is LOW from the next cycle.
- R3: If any of the first three copies differs from the others, vote_o stays HIGH for that group.
- R4: While early_en_i is LOW, vote_o is HIGH from the next cycle on.
- R5: Once the group has voted early, vote_o returns HIGH exactly (setup_sel_i+1)*SETUP_STEP cycles after the edge that samples repeat 4. A frame_sync_i pulse returns it HIGH in the next cycle.
- R6: busy_o is the majority of the last three bits sampled with busy_valid_i, and LOW means idle. The history is all-zero after reset.
- R7: With filler_filt_en_i HIGH, a voted filler word (filler flag 1) whose FILL_MASK bits equal those of the previous voted filler word is not forwarded. An error-free voted non-filler word breaks the chain.
- R8: The stored filler word is cleared by reset, so the first filler word after reset is forwarded.
- R9: With bch_filt_en_i HIGH, a voted word whose error flag is 1 is not forwarded. With it LOW, such a word is forwarded.
- R10: frame_sync_i restarts the repeat index at 0. A word strobed in the same cycle counts as repeat 0.
- R11: After reset, vote_o is HIGH, busy_o is LOW and fwd_o is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | Frame restart pulse |
| word_valid_i | input | 1 | Strobe for one received word copy |
| word_i | input | WORD_W | Received word copy |
| bch_err_i | input | 1 | BCH error flag of this copy |
| filler_i | input | 1 | Filler-word flag of this copy |
| busy_valid_i | input | 1 | Strobe for one busy/idle bit |
| busy_bit_i | input | 1 | Busy/idle bit |
| early_en_i | input | 1 | Enables the early 3-copy vote |
| setup_sel_i | input | 2 | Release delay select |
| filler_filt_en_i | input | 1 | Enables the repeated filler filter |
| bch_filt_en_i | input | 1 | Enables the BCH error filter |
| vote_o | output | 1 | Early vote pin, LOW when the first three copies agree |
| busy_o | output | 1 | Channel busy, LOW means idle |
| fwd_o | output | 1 | Forward strobe for the voted word |
| fwd_word_o | output | WORD_W | Voted word |

## Verification
Some properties are checked on every cycle. vote_o is held HIGH whenever early voting is off. It only falls in the cycle after a sampled word. busy_o only changes after a sampled busy/idle bit. fwd_o only pulses in the cycle after a sampled word. Other behaviour needs the bench scenarios: the true bitwise majority over mixed copies, the exact release delay for two settings of setup_sel_i, the effect of a frame restart in mid-group, and which filler and errored words are dropped. These depend on the history of whole groups.

// File: rtl/fcv_pkg.sv
package fcv_pkg;
  localparam int REPEATS  = 5;
  localparam int EARLY_AT = 2;   // index of third copy
  localparam int IDX_W    = $clog2(REPEATS);

  typedef struct packed {
    logic err;
    logic fil;
  } word_flags_t;
endpackage

// File: rtl/fcv_copy_store.sv
module fcv_copy_store
  import fcv_pkg::*;
#(
  parameter int W = 30
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sync_i,
  input  logic                           valid_i,
  input  logic [W-1:0]                   data_i,
  output logic [IDX_W-1:0]               idx_o,
  output logic [REPEATS-2:0][W-1:0]      copies_o
);
  logic [IDX_W-1:0]          idx_q;
  logic [REPEATS-2:0][W-1:0] copies_q;

  assign idx_o    = sync_i ? '0 : idx_q;
  assign copies_o = copies_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      copies_q <= '0;
    end else if (valid_i) begin
      idx_q <= (idx_o == IDX_W'(REPEATS - 1)) ? '0 : idx_o + 1'b1;
      for (int k = 0; k < REPEATS - 1; k++)
        if (idx_o == IDX_W'(k)) copies_q[k] <= data_i;
    end else if (sync_i) begin
      idx_q <= '0;
    end
  end
endmodule

// File: rtl/fcv_maj5.sv
module fcv_maj5 #(
  parameter int W = 30
) (
  input  logic [4:0][W-1:0] v_i,
  output logic [W-1:0]      maj_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [2:0] sum;
    assign sum = {2'b0, v_i[0][b]} + {2'b0, v_i[1][b]} + {2'b0, v_i[2][b]}
               + {2'b0, v_i[3][b]} + {2'b0, v_i[4][b]};
    assign maj_o[b] = (sum >= 3'd3);
  end
endmodule

// File: rtl/fcv_busy_vote.sv
module fcv_busy_vote #(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic busy_o
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (valid_i) hist_q <= {hist_q[DEPTH-2:0], bit_i};
  end

  assign busy_o = ($countones(hist_q) > CW'(DEPTH / 2));
endmodule

// File: rtl/fcv_fwd_filter.sv
module fcv_fwd_filter
  import fcv_pkg::*;
#(
  parameter int          W         = 28,
  parameter logic [W-1:0] FILL_MASK = '1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strobe_i,
  input  word_flags_t flags_i,
  input  logic [W-1:0] word_i,
  input  logic        fill_en_i,
  input  logic        bch_en_i,
  output logic        fwd_o,
  output logic [W-1:0] word_o
);
  logic [W-1:0] prev_q;
  logic         prev_vld_q;
  logic         drop_err, drop_fill;

  assign drop_err  = bch_en_i && flags_i.err;
  assign drop_fill = fill_en_i && flags_i.fil && prev_vld_q
                  && (((word_i ^ prev_q) & FILL_MASK) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_o      <= 1'b0;
      word_o     <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      fwd_o <= strobe_i && !drop_err && !drop_fill;
      if (strobe_i) begin
        word_o <= word_i;
        if (!flags_i.err) begin
          prev_vld_q <= flags_i.fil;
          if (flags_i.fil) prev_q <= word_i;
        end
      end
    end
  end
endmodule

// File: rtl/fcv_voter.sv
module fcv_voter
  import fcv_pkg::*;
#(
  parameter int                WORD_W     = 28,
  parameter int                SETUP_STEP = 4,
  parameter logic [WORD_W-1:0] FILL_MASK  = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_sync_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              bch_err_i,
  input  logic              filler_i,
  input  logic              busy_valid_i,
  input  logic              busy_bit_i,
  input  logic              early_en_i,
  input  logic [1:0]        setup_sel_i,
  input  logic              filler_filt_en_i,
  input  logic              bch_filt_en_i,
  output logic              vote_o,
  output logic              busy_o,
  output logic              fwd_o,
  output logic [WORD_W-1:0] fwd_word_o
);
  localparam int DW    = WORD_W + 2;
  localparam int REL_W = $clog2(4 * SETUP_STEP + 1);

  logic [DW-1:0]                in_vec, voted;
  logic [IDX_W-1:0]             idx;
  logic [REPEATS-2:0][DW-1:0]   copies;
  logic [4:0][DW-1:0]           all_copies;
  logic                         early_hit, last_rep;
  logic                         low_q;
  logic [REL_W-1:0]             rel_q;
  word_flags_t                  vflags;

  assign in_vec = {bch_err_i, filler_i, word_i};

  fcv_copy_store #(.W(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (frame_sync_i),
    .valid_i (word_valid_i),
    .data_i  (in_vec),
    .idx_o   (idx),
    .copies_o(copies)
  );

  assign all_copies[3:0] = copies;
  assign all_copies[4]   = in_vec;

  fcv_maj5 #(.W(DW)) u_maj (
    .v_i  (all_copies),
    .maj_o(voted)
  );

  assign early_hit = word_valid_i && (idx == IDX_W'(EARLY_AT))
                  && (copies[0][WORD_W-1:0] == copies[1][WORD_W-1:0])
                  && (copies[1][WORD_W-1:0] == word_i);
  assign last_rep  = word_valid_i && (idx == IDX_W'(REPEATS - 1));

  // early vote pin with delayed release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= 1'b0;
      rel_q <= '0;
    end else if (!early_en_i || frame_sync_i) begin
      low_q <= 1'b0;
      rel_q <= '0;
    end else begin
      if (early_hit) low_q <= 1'b1;
      if (last_rep && low_q) begin
        rel_q <= REL_W'((int'(setup_sel_i) + 1) * SETUP_STEP);
      end else if (rel_q != '0) begin
        rel_q <= rel_q - 1'b1;
        if (rel_q == REL_W'(1)) low_q <= 1'b0;
      end
    end
  end

  assign vote_o = !low_q;

  fcv_busy_vote #(.DEPTH(3)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(busy_valid_i),
    .bit_i  (busy_bit_i),
    .busy_o (busy_o)
  );

  assign vflags = word_flags_t'(voted[DW-1:WORD_W]);

  fcv_fwd_filter #(.W(WORD_W), .FILL_MASK(FILL_MASK)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (last_rep),
    .flags_i  (vflags),
    .word_i   (voted[WORD_W-1:0]),
    .fill_en_i(filler_filt_en_i),
    .bch_en_i (bch_filt_en_i),
    .fwd_o    (fwd_o),
    .word_o   (fwd_word_o)
  );
endmodule

// File: rtl/fcv_voter_chk.sv
module fcv_voter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic word_valid_i,
  input logic early_en_i,
  input logic busy_valid_i,
  input logic vote_o,
  input logic busy_o,
  input logic fwd_o
);
  // R4
  vote_high_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !early_en_i |=> vote_o);

  // R2
  vote_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vote_o) |-> $past(word_valid_i && early_en_i));

  // R6
  busy_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(busy_o) |-> $past(busy_valid_i));

  // R1
  fwd_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> $past(word_valid_i));
endmodule

bind fcv_voter fcv_voter_chk u_chk (.*);

// File: tb/fcv_voter_tb.sv
module fcv_voter_tb_top;
  localparam int W    = 28;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 0, word_valid = 0, bch_err = 0, filler = 0;
  logic busy_valid = 0, busy_bit = 0;
  logic early_en = 1, fill_en = 0, bch_en = 0;
  logic [1:0] setup_sel = 0;
  logic [W-1:0] word = '0;
  logic vote, busy, fwd;
  logic [W-1:0] fwd_word;

  int total = 0, fails = 0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;

  fcv_voter #(.WORD_W(W), .SETUP_STEP(STEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_sync_i(frame_sync),
    .word_valid_i(word_valid), .word_i(word), .bch_err_i(bch_err),
    .filler_i(filler), .busy_valid_i(busy_valid), .busy_bit_i(busy_bit),
    .early_en_i(early_en), .setup_sel_i(setup_sel),
    .filler_filt_en_i(fill_en), .bch_filt_en_i(bch_en),
    .vote_o(vote), .busy_o(busy), .fwd_o(fwd), .fwd_word_o(fwd_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor: pop and compare forwarded words
  always @(posedge clk) begin
    #1;
    if (rst_n && fwd) begin
      if (exp_q.size() == 0) chk("R7 R9 unexpected forward", 32'(fwd_word), 32'hdead);
      else chk("R1 forwarded word", 32'(fwd_word), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic send_one(input logic [W-1:0] w, input logic e, input logic f);
    @(negedge clk);
    word_valid = 1; word = w; bch_err = e; filler = f;
    @(negedge clk);
    word_valid = 0;
  endtask

  task automatic send_group(input logic [4:0][W-1:0] c, input logic e, input logic f,
                            input logic exp_vote3, input logic exp_fwd,
                            input logic [W-1:0] exp_word, input string req);
    if (exp_fwd) exp_q.push_back(exp_word);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k == 3) chk({req, " vote after third copy"}, 32'(vote), 32'(exp_vote3));
      word_valid = 1; word = c[k]; bch_err = e; filler = f;
    end
    @(negedge clk);
    word_valid = 0;
    chk({req, " forward strobe"}, 32'(fwd), 32'(exp_fwd));
  endtask

  task automatic check_release(input int n, input string req);
    for (int i = 1; i < n; i++) @(negedge clk);
    chk({req, " vote still low before delay"}, 32'(vote), 0);
    @(negedge clk);
    chk({req, " vote high after delay"}, 32'(vote), 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_busy(input logic b, input logic exp);
    @(negedge clk);
    busy_valid = 1; busy_bit = b;
    @(negedge clk);
    busy_valid = 0;
    chk("R6 busy majority", 32'(busy), 32'(exp));
  endtask

  localparam logic [W-1:0] A = 28'h0A5C3E1;
  localparam logic [W-1:0] F = 28'h0123456;
  localparam logic [W-1:0] X = 28'h0FEDCBA;

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk("R11 reset vote", 32'(vote), 1);
    chk("R11 reset busy", 32'(busy), 0);
    chk("R11 reset fwd", 32'(fwd), 0);

    // R2 R1 R5: identical group, early vote, release after 4 cycles
    send_group({A, A, A, A, A}, 0, 0, 0, 1, A, "R2");
    check_release((0 + 1) * STEP, "R5 sel0");

    // R5 with a longer setting
    setup_sel = 2'd2;
    send_group({A, A, A, A, A}, 0, 0, 0, 1, A, "R2 sel2");
    check_release((2 + 1) * STEP, "R5 sel2");

    // R3: copy 1 differs, vote stays high, majority still A
    send_group({A ^ 28'h2, A, A, A ^ 28'h1, A}, 0, 0, 1, 1, A, "R3");
    idle(2);
    chk("R3 vote stays high", 32'(vote), 1);

    // R1 true bitwise majority over mixed copies: A,B,C,A,B -> 0x0FF
    send_group({28'h0F0, 28'h0FF, 28'h00F, 28'h0F0, 28'h0FF}, 0, 0, 1, 1, 28'h0FF, "R1 mixed");
    idle(2);

    // R4: early vote disabled
    early_en = 0;
    send_group({A, A, A, A, A}, 0, 0, 1, 1, A, "R4");
    chk("R4 vote high", 32'(vote), 1);
    early_en = 1;
    idle(2);

    // R5: frame sync releases vote at once
    setup_sel = 2'd3;
    send_group({A, A, A, A, A}, 0, 0, 0, 1, A, "R5 sync");
    @(negedge clk); frame_sync = 1;
    @(negedge clk); frame_sync = 0;
    chk("R5 sync releases vote", 32'(vote), 1);
    setup_sel = 2'd0;

    // R10: partial group then sync restarts repeat count
    send_one(X, 0, 0);
    send_one(X, 0, 0);
    @(negedge clk); frame_sync = 1;
    @(negedge clk); frame_sync = 0;
    send_group({F, F, F, F, F}, 0, 0, 0, 1, F, "R10");
    idle(2 * STEP);

    // R8 R7: filler filter
    fill_en = 1;
    send_group({F, F, F, F, F}, 0, 1, 0, 1, F, "R8 first filler");
    idle(STEP + 1);
    send_group({F, F, F, F, F}, 0, 1, 0, 0, F, "R7 repeat filler dropped");
    idle(STEP + 1);
    send_group({X, X, X, X, X}, 0, 0, 0, 1, X, "R7 non-filler");
    idle(STEP + 1);
    send_group({F, F, F, F, F}, 0, 1, 0, 1, F, "R7 chain broken");
    idle(STEP + 1);
    send_group({F, F, F, F, F}, 0, 1, 0, 0, F, "R7 repeat again dropped");
    idle(STEP + 1);
    fill_en = 0;

    // R9: BCH error filter
    bch_en = 1;
    send_group({X, X, X, X, X}, 1, 0, 0, 0, X, "R9 errored dropped");
    idle(STEP + 1);
    bch_en = 0;
    send_group({A, A, A, A, A}, 1, 0, 0, 1, A, "R9 filter off");
    idle(STEP + 1);

    // R6: busy majority
    send_busy(1, 0);
    send_busy(1, 1);
    send_busy(0, 1);
    send_busy(0, 0);
    send_busy(1, 0);

    idle(4);
    chk("R1 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule